// File: doc/BRIEF.md
# Capability Dword Window

This block lets configuration software reach a larger controller register file through a small 8-byte capability structure. Inside that structure there is a select byte and a 32-bit data register. The data register always shows the register-file dword that the select byte picks. The register-file byte address is the select value times four.

When the capability accepts a write, the block starts a fixed three-cycle sequence. In the first cycle it forwards the data register to the register file, but only if the write touched the data dword. In the second cycle it reads the selected dword back. In the third cycle it loads the result into the data register. Any side effect of a register-file write, such as bits that clear themselves, is therefore visible in the window on the next read.

While the sequence runs, `cap_busy` is high and capability writes are not taken. Dwords at or beyond the implemented register-file size read as zero and are never accessed.

Top module: `cap_dword_window`

## Requirements
- R1: After reset the select byte and the data register are 0, both capability dwords read 0, and `cap_busy` is low.
- R2: The select byte is byte lane 2 of the capability dword at `CAP_DW_BASE` and is written by `cap_be[2]`. Lanes 0, 1 and 3 of that dword always read 0.
- R3: The data register is the dword at `CAP_DW_BASE+1`. Each byte changes only when its own `cap_be` bit is set.
- R4: A write that touches the data dword produces exactly one `rf_wr` pulse. The pulse carries the full 32-bit merged data value at `rf_addr` = select×4.
- R5: After every accepted capability write, the data register is reloaded from the dword at select×4, including writes that change only the select byte.
- R6: The reloaded value is whatever the register file returns, not the value that was written. Register-file side effects are therefore visible.
- R7: If select×4 ≥ `RF_BYTES`, no `rf_wr` or `rf_rd` is issued and the data register reloads as 0.
- R8: An accepted write holds `cap_busy` high for exactly 3 cycles. The read data is registered one cycle after `rf_rd`.
- R9: Capability writes presented while `cap_busy` is high are dropped and change no state.
- R10: Writes outside the two capability dwords, or with all byte enables clear, are ignored. They start no sequence and cause no register-file access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_wr | input | 1 | Capability-side write strobe |
| cap_addr | input | CAP_AW | Configuration dword address |
| cap_be | input | 4 | Byte enables, little-endian lanes |
| cap_wdata | input | 32 | Write data |
| cap_rdata | output | 32 | Combinational read data for `cap_addr` |
| cap_busy | output | 1 | Forward/refresh sequence in progress |
| rf_addr | output | SEL_W+2 | Register-file byte address (select×4) |
| rf_wr | output | 1 | Register-file dword write strobe |
| rf_wdata | output | 32 | Register-file write data |
| rf_rd | output | 1 | Register-file read strobe |
| rf_rdata | input | 32 | Register-file read data, valid one cycle after `rf_rd` |

## Verification
The window state would first appear wrong through `cap_rdata` on the data dword:
- A wrong lane merge shows as a bad value on the first `rf_wr`.
- A missing or late refresh shows as the written value instead of the side-effected one, three cycles after the write.
- A broken range check shows as a strobe with an out-of-range address, or as stale non-zero data for an unimplemented dword.

A sequencer stuck in a non-idle state shows immediately as `cap_busy` staying high and later writes being dropped.

// File: rtl/cdw_pkg.sv
package cdw_pkg;

    localparam int unsigned SEL_W    = 8;
    localparam int unsigned LANES    = 4;
    localparam int unsigned SEQ_LEN  = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_RD   = 2'd2,
        ST_CAP  = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       fwd;
    } seq_regs_t;

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic [LANES*8-1:0] data;
    } win_regs_t;

endpackage

// File: rtl/cdw_range.sv
module cdw_range
    import cdw_pkg::*;
#(
    parameter int unsigned RF_BYTES = 160,
    localparam int unsigned RF_AW   = SEL_W + 2
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [RF_AW-1:0] addr_o,
    output logic             in_range_o
);
    logic [31:0] byte_addr;

    always_comb begin
        byte_addr  = 32'({sel_i, 2'b00});
        addr_o     = {sel_i, 2'b00};
        in_range_o = (byte_addr < 32'(RF_BYTES));
    end
endmodule

// File: rtl/cdw_seq.sv
module cdw_seq
    import cdw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic fwd_i,
    output logic busy_o,
    output logic wr_phase_o,
    output logic rd_phase_o,
    output logic cap_phase_o,
    output logic fwd_o
);
    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st  = ST_FWD;
                    seq_d.fwd = fwd_i;
                end
            end
            ST_FWD:  seq_d.st = ST_RD;
            ST_RD:   seq_d.st = ST_CAP;
            ST_CAP: begin
                seq_d.st  = ST_IDLE;
                seq_d.fwd = 1'b0;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st  <= ST_IDLE;
            seq_q.fwd <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o      = (seq_q.st != ST_IDLE);
    assign wr_phase_o  = (seq_q.st == ST_FWD);
    assign rd_phase_o  = (seq_q.st == ST_RD);
    assign cap_phase_o = (seq_q.st == ST_CAP);
    assign fwd_o       = seq_q.fwd;

    a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    a_r8_fwd_then_rd: assert property (@(posedge clk) disable iff (!rst_n)
        wr_phase_o |=> rd_phase_o);
    a_r5_rd_then_cap: assert property (@(posedge clk) disable iff (!rst_n)
        rd_phase_o |=> cap_phase_o);
    a_r8_cap_ends: assert property (@(posedge clk) disable iff (!rst_n)
        cap_phase_o |=> !busy_o);
    a_r8_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_phase_o, rd_phase_o, cap_phase_o}));
endmodule

// File: rtl/cdw_cap_regs.sv
module cdw_cap_regs
    import cdw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_we_i,
    input  logic [SEL_W-1:0]   sel_wdata_i,
    input  logic [LANES-1:0]   data_be_i,
    input  logic [LANES*8-1:0] data_wdata_i,
    input  logic               load_i,
    input  logic [LANES*8-1:0] load_data_i,
    output logic [SEL_W-1:0]   sel_o,
    output logic [LANES*8-1:0] data_o
);
    win_regs_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (sel_we_i) begin
            win_d.sel = sel_wdata_i;
        end
        for (int b = 0; b < int'(LANES); b++) begin
            if (data_be_i[b]) begin
                win_d.data[b*8 +: 8] = data_wdata_i[b*8 +: 8];
            end
        end
        if (load_i) begin
            win_d.data = load_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign sel_o  = win_q.sel;
    assign data_o = win_q.data;

    a_r3_idle_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && data_be_i == '0) |=> $stable(data_o));
    a_r2_idle_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_we_i |=> $stable(sel_o));
endmodule

// File: rtl/cap_dword_window.sv
module cap_dword_window
    import cdw_pkg::*;
#(
    parameter int unsigned CAP_AW      = 6,
    parameter int unsigned CAP_DW_BASE = 16,
    parameter int unsigned RF_BYTES    = 160,
    localparam int unsigned RF_AW      = SEL_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_wr,
    input  logic [CAP_AW-1:0] cap_addr,
    input  logic [3:0]        cap_be,
    input  logic [31:0]       cap_wdata,
    output logic [31:0]       cap_rdata,
    output logic              cap_busy,
    output logic [RF_AW-1:0]  rf_addr,
    output logic              rf_wr,
    output logic [31:0]       rf_wdata,
    output logic              rf_rd,
    input  logic [31:0]       rf_rdata
);
    localparam logic [CAP_AW-1:0] HDR_DW  = CAP_AW'(CAP_DW_BASE);
    localparam logic [CAP_AW-1:0] DATA_DW = CAP_AW'(CAP_DW_BASE + 1);
    localparam int unsigned       SEL_LSB = 16;

    logic              hit_hdr, hit_data, touch, accept;
    logic              sel_we;
    logic [3:0]        data_be;
    logic [SEL_W-1:0]  sel_q;
    logic [31:0]       data_q;
    logic              wr_phase, rd_phase, cap_phase, fwd_q;
    logic              in_range;
    logic [31:0]       load_data;

    always_comb begin
        hit_hdr  = (cap_addr == HDR_DW);
        hit_data = (cap_addr == DATA_DW);
        touch    = cap_wr && (cap_be != 4'b0000) && (hit_hdr || hit_data);
        accept   = touch && !cap_busy;
        sel_we   = accept && hit_hdr && cap_be[2];
        data_be  = (accept && hit_data) ? cap_be : 4'b0000;
    end

    cdw_seq i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (accept),
        .fwd_i       (hit_data),
        .busy_o      (cap_busy),
        .wr_phase_o  (wr_phase),
        .rd_phase_o  (rd_phase),
        .cap_phase_o (cap_phase),
        .fwd_o       (fwd_q)
    );

    cdw_cap_regs i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_we_i     (sel_we),
        .sel_wdata_i  (cap_wdata[SEL_LSB +: SEL_W]),
        .data_be_i    (data_be),
        .data_wdata_i (cap_wdata),
        .load_i       (cap_phase),
        .load_data_i  (load_data),
        .sel_o        (sel_q),
        .data_o       (data_q)
    );

    cdw_range #(.RF_BYTES(RF_BYTES)) i_range (
        .sel_i      (sel_q),
        .addr_o     (rf_addr),
        .in_range_o (in_range)
    );

    always_comb begin
        rf_wr     = wr_phase && fwd_q && in_range;
        rf_rd     = rd_phase && in_range;
        rf_wdata  = data_q;
        load_data = in_range ? rf_rdata : 32'h0;
        if (cap_addr == HDR_DW) begin
            cap_rdata = 32'h0;
            cap_rdata[SEL_LSB +: SEL_W] = sel_q;
        end else if (cap_addr == DATA_DW) begin
            cap_rdata = data_q;
        end else begin
            cap_rdata = 32'h0;
        end
    end

    a_r7_rf_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr || rf_rd) |-> (32'(rf_addr) < 32'(RF_BYTES)));
    a_r4_single_wr: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr |=> !rf_wr);
    a_r9_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cap_busy |=> $stable(sel_q));
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_busy && !touch) |=> !cap_busy);
    a_r5_rd_before_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_rd) |=> cap_phase);
endmodule

// File: tb/test_cap_dword_window.sv
module test_cap_dword_window;
    localparam int unsigned CAP_AW   = 6;
    localparam int unsigned BASE     = 16;
    localparam int unsigned RF_BYTES = 160;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_wr = 1'b0;
    logic [5:0]  cap_addr = 6'd0;
    logic [3:0]  cap_be = 4'd0;
    logic [31:0] cap_wdata = 32'd0;
    logic [31:0] cap_rdata;
    logic        cap_busy;
    logic [9:0]  rf_addr;
    logic        rf_wr;
    logic [31:0] rf_wdata;
    logic        rf_rd;
    logic [31:0] rf_rdata = 32'd0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] mem [64];
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    logic [9:0]  last_waddr = '0;
    logic [31:0] last_wdata = '0;

    always #5 clk = ~clk;

    cap_dword_window #(.CAP_AW(CAP_AW), .CAP_DW_BASE(BASE), .RF_BYTES(RF_BYTES)) i_cap_dword_window (
        .clk(clk), .rst_n(rst_n), .cap_wr(cap_wr), .cap_addr(cap_addr),
        .cap_be(cap_be), .cap_wdata(cap_wdata), .cap_rdata(cap_rdata),
        .cap_busy(cap_busy), .rf_addr(rf_addr), .rf_wr(rf_wr),
        .rf_wdata(rf_wdata), .rf_rd(rf_rd), .rf_rdata(rf_rdata)
    );

    // Register-file model: dword 7 clears the bits written as 1.
    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h1000_0000 + i;
        mem[7] = 32'hFFFF_0000;
    end

    always @(posedge clk) begin
        if (rf_wr) begin
            wr_cnt     <= wr_cnt + 1;
            last_waddr <= rf_addr;
            last_wdata <= rf_wdata;
            if (rf_addr[9:2] == 8'd7) mem[7] <= mem[7] & ~rf_wdata;
            else if (rf_addr[9:2] < 8'd64) mem[rf_addr[7:2]] <= rf_wdata;
        end
        if (rf_rd) begin
            rd_cnt   <= rd_cnt + 1;
            rf_rdata <= (rf_addr[9:2] < 8'd64) ? mem[rf_addr[7:2]] : 32'hDEAD_BEEF;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cap_wr = 1'b1; cap_addr = a; cap_be = be; cap_wdata = d;
        @(negedge clk);
        cap_wr = 1'b0; cap_be = 4'd0;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 20 && cap_busy; g++) @(negedge clk);
    endtask

    task automatic cap_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        wait_idle();
        drive(a, be, d);
        wait_idle();
    endtask

    task automatic cap_read(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        cap_addr = a;
        #1 v = cap_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        cap_read(6'(BASE), v);     check("R1 hdr", v, 32'h0);
        cap_read(6'(BASE + 1), v); check("R1 data", v, 32'h0);
        check("R1 busy", 32'(cap_busy), 32'h0);
    endtask

    task automatic t_select();
        logic [31:0] v;
        int w0;
        w0 = wr_cnt;
        cap_write(6'(BASE), 4'b0100, 32'h0003_0000);
        cap_read(6'(BASE), v);     check("R2 sel lane2", v, 32'h0003_0000);
        cap_read(6'(BASE + 1), v); check("R5 refresh on select", v, 32'h1000_0003);
        check("R4 no fwd on select", 32'(wr_cnt - w0), 32'h0);
        cap_write(6'(BASE), 4'b1111, 32'hAB05_CDEF);
        cap_read(6'(BASE), v);     check("R2 other lanes zero", v, 32'h0005_0000);
    endtask

    task automatic t_forward();
        logic [31:0] v;
        int w0;
        w0 = wr_cnt;
        cap_write(6'(BASE + 1), 4'b1111, 32'hCAFE_F00D);
        check("R4 one write", 32'(wr_cnt - w0), 32'h1);
        check("R4 addr", 32'(last_waddr), 32'd20);
        check("R4 data", last_wdata, 32'hCAFE_F00D);
        cap_read(6'(BASE + 1), v); check("R5 readback", v, 32'hCAFE_F00D);
    endtask

    task automatic t_merge();
        logic [31:0] v;
        cap_write(6'(BASE + 1), 4'b0010, 32'h1111_5A22);
        check("R3 merged fwd", last_wdata, 32'hCAFE_5A0D);
        cap_read(6'(BASE + 1), v); check("R3 merged read", v, 32'hCAFE_5A0D);
    endtask

    task automatic t_side_effect();
        logic [31:0] v;
        cap_write(6'(BASE), 4'b0100, 32'h0007_0000);
        cap_read(6'(BASE + 1), v); check("R5 window dw7", v, 32'hFFFF_0000);
        cap_write(6'(BASE + 1), 4'b1111, 32'h0F0F_0000);
        cap_read(6'(BASE + 1), v); check("R6 side effect", v, 32'hF0F0_0000);
    endtask

    task automatic t_timing();
        int n;
        wait_idle();
        drive(6'(BASE), 4'b0100, 32'h0005_0000);
        n = 0;
        for (int g = 0; g < 10 && cap_busy; g++) begin
            n++;
            @(negedge clk);
        end
        check("R8 busy cycles", 32'(n), 32'd3);
    endtask

    task automatic t_stall();
        logic [31:0] v;
        int w0;
        wait_idle();
        w0 = wr_cnt;
        drive(6'(BASE), 4'b0100, 32'h0006_0000);
        check("R8 busy after accept", 32'(cap_busy), 32'h1);
        cap_wr = 1'b1; cap_addr = 6'(BASE); cap_be = 4'b0100; cap_wdata = 32'h0009_0000;
        @(negedge clk);
        cap_wr = 1'b1; cap_addr = 6'(BASE + 1); cap_be = 4'b1111; cap_wdata = 32'h5555_5555;
        @(negedge clk);
        cap_wr = 1'b0; cap_be = 4'd0;
        wait_idle();
        cap_read(6'(BASE), v);     check("R9 sel kept", v, 32'h0006_0000);
        cap_read(6'(BASE + 1), v); check("R9 data refreshed only", v, 32'h1000_0006);
        check("R9 no fwd", 32'(wr_cnt - w0), 32'h0);
    endtask

    task automatic t_oob();
        logic [31:0] v;
        int w0, r0;
        cap_write(6'(BASE), 4'b0100, 32'h0027_0000);
        cap_read(6'(BASE + 1), v); check("R7 last dword", v, 32'h1000_0027);
        w0 = wr_cnt; r0 = rd_cnt;
        cap_write(6'(BASE), 4'b0100, 32'h0028_0000);
        cap_read(6'(BASE + 1), v); check("R7 oob reads zero", v, 32'h0);
        cap_write(6'(BASE + 1), 4'b1111, 32'h1234_5678);
        cap_read(6'(BASE + 1), v); check("R7 oob write zero", v, 32'h0);
        check("R7 no rf write", 32'(wr_cnt - w0), 32'h0);
        check("R7 no rf read", 32'(rd_cnt - r0), 32'h0);
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        int w0, r0;
        cap_write(6'(BASE), 4'b0100, 32'h0004_0000);
        w0 = wr_cnt; r0 = rd_cnt;
        drive(6'(BASE + 2), 4'b1111, 32'hFFFF_FFFF);
        check("R10 outside no busy", 32'(cap_busy), 32'h0);
        drive(6'(BASE + 1), 4'b0000, 32'hFFFF_FFFF);
        check("R10 no lanes no busy", 32'(cap_busy), 32'h0);
        cap_read(6'(BASE + 1), v); check("R10 data unchanged", v, 32'h1000_0004);
        check("R10 no rf traffic", 32'((wr_cnt - w0) + (rd_cnt - r0)), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select();
        t_forward();
        t_merge();
        t_side_effect();
        t_timing();
        t_stall();
        t_oob();
        t_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule